// File: doc/BRIEF.md
# Nibble-Multiplication Substitution Box

This block maps each byte to a new byte through two chained multiplications in the four-bit Galois field GF(2^4). The input byte is split into a high nibble `a` and a low nibble `b`. A first nibble `B` is the product of `a` and `b`, unless `b` is zero, in which case `B` is simply `a`. A second nibble `A` is the product of `b` and `B`, unless `B` is zero, in which case `A` is simply `b`. `A` and `B` are packed into a byte and XORed with a fixed constant. Every zero test is a four-input OR reduction that drives a 2:1 multiplexer, so no full product is ever selected when a factor is zero.

The mapping is a bijection on all 256 byte values. It can stand in for a lookup-table substitution stage at a fraction of the logic. Both the reduction polynomial and the output constant are parameters. The same polynomial serves both multipliers.

Bytes move through a valid/ready stream interface. With `REG_OUT = 1` (the default), one register stage sits at the output. A byte is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. The result is offered on the next cycle and is held until `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. With `REG_OUT = 0`, the path is combinational and the handshake passes straight through.

Top module: `nibmul_sbox`

## Requirements
- R1: With `a = in_byte[7:4]` and `b = in_byte[3:0]` and `b` non-zero, the pre-mask nibble `B` equals `a` multiplied by `b` in GF(2^4). The reduction polynomial is `x^4 + RED_POLY`, with default `RED_POLY = 4'b0011` (x^4 + x + 1).
- R2: When `b` is zero, `B` equals `a`.
- R3: When `B` is zero, `A` equals `b`. In particular, any input with `a = 0` gives `A = b`.
- R4: When `B` is non-zero, `A` equals `b` multiplied by `B` in GF(2^4), using the same polynomial as R1.
- R5: `out_byte` equals `{A, B} ^ OUT_XOR`, with `A` in bits 7..4, `B` in bits 3..0, and default `OUT_XOR = 8'h63`.
- R6: Over all 256 inputs, the outputs are pairwise distinct.
- R7: With `REG_OUT = 1`, `out_valid` is low after reset. A byte accepted at one edge appears on `out_byte` with `out_valid` high from that edge onward. `out_valid` falls after a transfer when no new byte is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_valid` hold, and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Substituted byte is offered |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
Hand-computed vectors separate the four selection paths:
- both nibbles zero;
- `b` zero only (B bypass);
- `a` zero only (A bypass);
- both nibbles non-zero, including operands whose products need reduction.

This shows which multiplexer branch, and which reduction term, is wrong. A full sweep of all 256 bytes is compared against an independently written long-division field model. The sweep also confirms that no two outputs collide, which exposes a wrong polynomial or nibble placement that hand vectors could miss. Directed sequences stall the consumer to test the hold behaviour, and idle the producer to test that `out_valid` drops.

// File: rtl/nibmul_sbox_pkg.sv
package nibmul_sbox_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/nibmul_gf16_mul.sv
module nibmul_gf16_mul
  import nibmul_sbox_pkg::*;
#(
  parameter nib_t RED_POLY = 4'h3
) (
  input  nib_t x,
  input  nib_t y,
  output nib_t p
);
  nib_t acc;

  // Horner shift-and-add: double the partial result, reduce, then add x.
  always_comb begin
    acc = '0;
    for (int i = NIB_W - 1; i >= 0; i--) begin
      acc = {acc[NIB_W-2:0], 1'b0} ^ (acc[NIB_W-1] ? RED_POLY : nib_t'(0));
      if (y[i]) acc = acc ^ x;
    end
    p = acc;
  end
endmodule

// File: rtl/nibmul_zero_sel.sv
module nibmul_zero_sel
  import nibmul_sbox_pkg::*;
(
  input  nib_t test_nib,
  input  nib_t product,
  input  nib_t bypass,
  output nib_t result
);
  logic nonzero;

  // Three two-input ORs, then a 2:1 mux.
  assign nonzero = (test_nib[0] | test_nib[1]) | (test_nib[2] | test_nib[3]);
  assign result  = nonzero ? product : bypass;
endmodule

// File: rtl/nibmul_sbox_core.sv
module nibmul_sbox_core
  import nibmul_sbox_pkg::*;
#(
  parameter nib_t  RED_POLY = 4'h3,
  parameter byte_t OUT_XOR  = 8'h63
) (
  input  byte_t din,
  output byte_t dout
);
  nib_t hi_n, lo_n, prod_b, prod_a, nib_b, nib_a;

  assign hi_n = din[BYTE_W-1:NIB_W];
  assign lo_n = din[NIB_W-1:0];

  nibmul_gf16_mul #(.RED_POLY(RED_POLY)) mul_first_i (
    .x(hi_n), .y(lo_n), .p(prod_b));

  nibmul_zero_sel sel_first_i (
    .test_nib(lo_n), .product(prod_b), .bypass(hi_n), .result(nib_b));

  nibmul_gf16_mul #(.RED_POLY(RED_POLY)) mul_second_i (
    .x(lo_n), .y(nib_b), .p(prod_a));

  nibmul_zero_sel sel_second_i (
    .test_nib(nib_b), .product(prod_a), .bypass(lo_n), .result(nib_a));

  assign dout = {nib_a, nib_b} ^ OUT_XOR;
endmodule

// File: rtl/nibmul_sbox.sv
module nibmul_sbox
  import nibmul_sbox_pkg::*;
#(
  parameter nib_t  RED_POLY = 4'h3,
  parameter byte_t OUT_XOR  = 8'h63,
  parameter bit    REG_OUT  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte
);
  byte_t sub_byte;

  nibmul_sbox_core #(.RED_POLY(RED_POLY), .OUT_XOR(OUT_XOR)) core_i (
    .din(in_byte), .dout(sub_byte));

  generate
    if (REG_OUT) begin : g_reg
      logic  vld_q;
      byte_t dat_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= sub_byte;
        end
      end

      assign out_valid = vld_q;
      assign out_byte  = dat_q;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_byte  = sub_byte;
    end
  endgenerate
endmodule

// File: rtl/nibmul_sbox_chk.sv
module nibmul_sbox_chk #(
  parameter logic [7:0] OUT_XOR = 8'h63,
  parameter bit         REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);
  generate
    if (REG_OUT) begin : g_chk
      // R8
      hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
      // R8
      no_accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
      // R7
      accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      // R2
      low_zero_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_byte[3:0] == 4'h0)
        |=> (out_byte[3:0] == ($past(in_byte[7:4]) ^ OUT_XOR[3:0])));
      // R3
      high_zero_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_byte[7:4] == 4'h0)
        |=> (out_byte[7:4] == ($past(in_byte[3:0]) ^ OUT_XOR[7:4])));
    end
  endgenerate
endmodule

bind nibmul_sbox nibmul_sbox_chk #(.OUT_XOR(OUT_XOR), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte));

// File: tb/nibmul_sbox_tb_top.sv
module nibmul_sbox_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Hand-computed vectors: {input, expected} for x^4+x+1 and mask 8'h63.
  localparam int NVEC = 11;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00_63, 16'h10_62, 16'h01_73, 16'h11_72, 16'h23_C5, 16'h22_E7,
    16'h88_CF, 16'hFF_A9, 16'h0F_93, 16'hF0_6C, 16'h57_BB};

  always #4 clk = ~clk;

  nibmul_sbox dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte));

  // Reference multiply: carry-less product, then long division by 1_0011.
  function automatic logic [3:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
    logic [6:0] prod = '0;
    for (int i = 0; i < 4; i++) if (y[i]) prod = prod ^ (7'(x) << i);
    for (int d = 6; d >= 4; d--) if (prod[d]) prod = prod ^ (7'h13 << (d - 4));
    return prod[3:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] v);
    logic [3:0] a = v[7:4], b = v[3:0], bb, aa;
    bb = (b == 4'h0) ? a : ref_mul(a, b);
    aa = (bb == 4'h0) ? b : ref_mul(b, bb);
    return {aa, bb} ^ 8'h63;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v, output logic [7:0] got, output logic vld);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = v;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_byte;
    vld = out_valid;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic vld;
    bit seen [256];
    int dup;

    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset out_valid", 8'(out_valid), 8'h00);
    check("R7 reset in_ready", 8'(in_ready), 8'h01);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: hand vectors
    for (int k = 0; k < NVEC; k++) begin
      send(VEC[k][15:8], got, vld);
      check("R7 valid after accept", 8'(vld), 8'h01);
      check("R1 R2 R3 R4 R5 vector", got, VEC[k][7:0]);
    end

    // R7: idle producer drops out_valid
    @(negedge clk);
    check("R7 valid falls when idle", 8'(out_valid), 8'h00);

    // R1 R4 R5 R6: exhaustive sweep against the model, with distinctness
    dup = 0;
    for (int v = 0; v < 256; v++) begin
      send(8'(v), got, vld);
      check("R1 R4 R5 sweep", got, ref_sbox(8'(v)));
      if (seen[got]) dup++;
      seen[got] = 1'b1;
    end
    check("R6 duplicate outputs", 8'(dup), 8'h00);

    // R8: stall the consumer
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_byte = 8'h23;
    @(negedge clk);
    in_byte = 8'h57;
    check("R8 in_ready low on stall", 8'(in_ready), 8'h00);
    repeat (3) @(negedge clk);
    check("R8 held valid", 8'(out_valid), 8'h01);
    check("R8 held byte", out_byte, 8'hC5);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next byte after release", out_byte, 8'hBB);
    @(negedge clk);
    check("R7 valid falls after drain", 8'(out_valid), 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule